// File: doc/BRIEF.md
# Memory-Backed Thread Scheduler

This block sits around a datapath that has been sliced into a fixed number of pipeline stages, so that several independent threads share the same logic over time. The block holds each thread's architectural state in a small memory addressed by thread number, in place of the original design registers. It also holds a controller that decides, every cycle, which stored thread enters the pipeline next. Any stored thread may be chosen in any order, as long as it is not already travelling through the pipeline. This lets the number of running threads vary from the stage count up to the memory depth. Processing time can also be shared unevenly between threads through programmable priorities.

Per-thread insert, stall and kill masks change the running set on any cycle. The launched thread's index and stored state go out to the datapath. The datapath's result comes back a fixed number of cycles later, aligned with the tag leaving the last stage, and is written into the memory at that thread's address. A keep input stands in for the original hold multiplexer: it gates the memory write enable, so the stored state does not change.

Top module: `thr_sched`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `lch_vld` and `wb_vld` are 0. Every thread is inactive. Every stored state is zero.
- R2: The tag launched in cycle n reaches the last of the `NSTG` stages in cycle n+`NSTG`-1. In that cycle `wb_idx` equals its index and `ret_data` is written to the memory entry of that index at the next clock edge.
- R3: A thread that occupies any of the first `NSTG`-1 stages is never launched. A single eligible thread therefore launches once every `NSTG` cycles and never sits in two stages at once.
- R4: Setting bit t of `ins_req` makes thread t active from the next cycle. A thread whose `stall_req` bit is high is not launched in that cycle but stays active.
- R5: Setting bit t of `kill_req` makes thread t inactive from the next cycle, and it outranks `ins_req`. If thread t is in the pipeline, its write-back is suppressed (`wb_vld` low), whether the kill arrives during its flight or in its write-back cycle.
- R6: Among the eligible threads (active, not stalled, not killed, not in the first `NSTG`-1 stages), the one with the numerically largest `PW`-bit field `prio[t*PW +: PW]` launches. Ties go to the lowest index.
- R7: `lch_vld` is high exactly when some thread was eligible in the previous cycle. A bubble carries no write-back: `wb_vld` stays low when it reaches the last stage.
- R8: While `ret_keep` is high, the write-back of the exiting thread leaves its stored state unchanged.
- R9: `lch_state` carries the launched thread's stored state. If that thread is being written back in the same cycle, `lch_state` carries the value being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_req | input | NTHR | Per-thread insert (activate) command |
| stall_req | input | NTHR | Per-thread launch hold for this cycle |
| kill_req | input | NTHR | Per-thread kill command |
| prio | input | NTHR*PW | Packed per-thread priority, thread t at bits t*PW +: PW |
| ret_data | input | SW | Datapath result for the tag in the last stage |
| ret_keep | input | 1 | Hold: suppress the memory write of the exiting thread |
| lch_vld | output | 1 | A thread was launched this cycle |
| lch_idx | output | $clog2(NTHR) | Index of the launched thread |
| lch_state | output | SW | Stored state of the launched thread |
| wb_vld | output | 1 | The last-stage tag is a live write-back |
| wb_idx | output | $clog2(NTHR) | Index of the thread in the last stage |

## Verification
The assertions assume that every command input has a known value from time zero. They also assume that `NTHR` is a power of two, so every index fits the memory, and that a priority and its eligibility are judged on the values present before the launching clock edge. The bench drives all inputs to zero before the first edge and changes them only at falling edges. It keeps to a configuration of eight threads and three stages. Its sweeps run from an idle set, through full occupancy with random priorities, stalls and hold, to random inserts and kills. A final pair of single-thread phases shows the every-third-cycle cadence with forwarded and held state.

// File: rtl/thr_sched_pkg.sv
package thr_sched_pkg;

    // widest thread index a tag can carry (up to 256 threads)
    localparam int TAG_W = 8;

    typedef struct packed {
        logic             vld;   // stage holds a launched thread
        logic             dead;  // thread was killed while in flight
        logic [TAG_W-1:0] idx;   // thread number
    } tag_t;

    // move a tag one stage further, marking it dead if its thread was killed
    function automatic tag_t age_tag(tag_t t, logic killed);
        tag_t r;
        r      = t;
        r.dead = t.dead | (t.vld & killed);
        return r;
    endfunction

endpackage

// File: rtl/thr_tag_pipe.sv
module thr_tag_pipe
    import thr_sched_pkg::*;
#(
    parameter int NTHR = 8,
    parameter int NSTG = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  tag_t            push,
    input  logic [NTHR-1:0] kill,
    output tag_t            first,
    output tag_t            last,
    output logic [NTHR-1:0] busy
);
    localparam int IW = $clog2(NTHR);

    tag_t stg [NSTG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < NSTG; k++) stg[k] <= '0;
        end else begin
            stg[0] <= push;
            for (int k = 1; k < NSTG; k++)
                stg[k] <= age_tag(stg[k-1], kill[stg[k-1].idx[IW-1:0]]);
        end
    end

    assign first = stg[0];
    assign last  = stg[NSTG-1];

    // a thread is busy while it sits in any stage except the last one
    for (genvar t = 0; t < NTHR; t++) begin : g_busy
        logic [NSTG-2:0] hit;
        for (genvar k = 0; k < NSTG-1; k++) begin : g_stg
            assign hit[k] = stg[k].vld && (stg[k].idx == TAG_W'(t));
        end
        assign busy[t] = |hit;
    end

endmodule

// File: rtl/thr_prio_pick.sv
module thr_prio_pick #(
    parameter int NTHR = 8,
    parameter int PW   = 2,
    localparam int IW  = $clog2(NTHR)
) (
    input  logic [NTHR-1:0]    elig,
    input  logic [NTHR*PW-1:0] prio,
    output logic               any,
    output logic [IW-1:0]      idx
);
    logic [PW-1:0] pv [NTHR];

    for (genvar i = 0; i < NTHR; i++) begin : g_unpack
        assign pv[i] = prio[i*PW +: PW];
    end

    always_comb begin
        logic [PW-1:0] best;
        logic          found;
        best  = '0;
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < NTHR; i++) begin
            // strict compare keeps the lower index on equal priority
            if (elig[i] && (!found || pv[i] > best)) begin
                found = 1'b1;
                best  = pv[i];
                idx   = IW'(i);
            end
        end
        any = found;
    end

endmodule

// File: rtl/thr_state_mem.sv
module thr_state_mem #(
    parameter int NTHR = 8,
    parameter int SW   = 8,
    localparam int IW  = $clog2(NTHR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [SW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [SW-1:0] rdata
);
    logic [SW-1:0] mem [NTHR];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NTHR; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // a read of the entry being written sees the new value
    assign rdata = (we && waddr == raddr) ? wdata : mem[raddr];

endmodule

// File: rtl/thr_sched.sv
module thr_sched
    import thr_sched_pkg::*;
#(
    parameter int NTHR = 8,
    parameter int NSTG = 3,
    parameter int SW   = 8,
    parameter int PW   = 2,
    localparam int IW  = $clog2(NTHR)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NTHR-1:0]    ins_req,
    input  logic [NTHR-1:0]    stall_req,
    input  logic [NTHR-1:0]    kill_req,
    input  logic [NTHR*PW-1:0] prio,
    input  logic [SW-1:0]      ret_data,
    input  logic               ret_keep,
    output logic               lch_vld,
    output logic [IW-1:0]      lch_idx,
    output logic [SW-1:0]      lch_state,
    output logic               wb_vld,
    output logic [IW-1:0]      wb_idx
);
    logic [NTHR-1:0] act_q;
    logic [NTHR-1:0] busy;
    logic [NTHR-1:0] elig;
    logic            pick_any;
    logic [IW-1:0]   pick_idx;
    logic [SW-1:0]   rd_state;
    logic            wr_en;
    tag_t            push_tag;
    tag_t            head_tag;
    tag_t            head_out;

    // active set: kill outranks insert
    always_ff @(posedge clk) begin
        if (rst) act_q <= '0;
        else     act_q <= (act_q | ins_req) & ~kill_req;
    end

    assign elig = act_q & ~stall_req & ~kill_req & ~busy;

    thr_prio_pick #(.NTHR(NTHR), .PW(PW)) u_pick (
        .elig (elig),
        .prio (prio),
        .any  (pick_any),
        .idx  (pick_idx)
    );

    always_comb begin
        push_tag      = '0;
        push_tag.vld  = pick_any;
        push_tag.dead = 1'b0;
        push_tag.idx  = TAG_W'(pick_idx);
    end

    thr_tag_pipe #(.NTHR(NTHR), .NSTG(NSTG)) u_pipe (
        .clk   (clk),
        .rst   (rst),
        .push  (push_tag),
        .kill  (kill_req),
        .first (head_out),
        .last  (head_tag),
        .busy  (busy)
    );

    assign lch_vld = head_out.vld;
    assign lch_idx = head_out.idx[IW-1:0];

    // write-back of the exiting tag, dropped for bubbles and killed threads
    assign wb_idx = head_tag.idx[IW-1:0];
    assign wb_vld = head_tag.vld && !head_tag.dead && !kill_req[wb_idx];
    assign wr_en  = wb_vld && !ret_keep;

    thr_state_mem #(.NTHR(NTHR), .SW(SW)) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (wb_idx),
        .wdata (ret_data),
        .raddr (pick_idx),
        .rdata (rd_state)
    );

    always_ff @(posedge clk) begin
        if (rst)           lch_state <= '0;
        else if (pick_any) lch_state <= rd_state;
    end

endmodule

// File: rtl/thr_sched_chk.sv
module thr_sched_chk #(
    parameter int NTHR = 8,
    parameter int PW   = 2,
    localparam int IW  = $clog2(NTHR)
) (
    input logic               clk,
    input logic               rst,
    input logic               lch_vld,
    input logic [IW-1:0]      lch_idx,
    input logic               wb_vld,
    input logic [IW-1:0]      wb_idx,
    input logic [NTHR-1:0]    busy,
    input logic [NTHR-1:0]    elig,
    input logic [NTHR-1:0]    act_q,
    input logic [NTHR-1:0]    stall_req,
    input logic [NTHR-1:0]    kill_req,
    input logic [NTHR*PW-1:0] prio
);
    logic [NTHR-1:0]    q_elig;
    logic [NTHR*PW-1:0] q_prio;
    logic               better;

    always_ff @(posedge clk) begin
        q_elig <= elig;
        q_prio <= prio;
    end

    always_comb begin
        logic [PW-1:0] sel;
        sel    = q_prio[lch_idx*PW +: PW];
        better = 1'b0;
        for (int i = 0; i < NTHR; i++) begin
            if (q_elig[i] && (q_prio[i*PW +: PW] > sel ||
                (q_prio[i*PW +: PW] == sel && i < int'(lch_idx))))
                better = 1'b1;
        end
    end

    a_r3_launch_not_busy: assert property (@(posedge clk) disable iff (rst)
        lch_vld |-> (($past(busy) & (NTHR'(1) << lch_idx)) == '0));

    a_r4_stalled_not_launched: assert property (@(posedge clk) disable iff (rst)
        lch_vld |-> (($past(stall_req) & (NTHR'(1) << lch_idx)) == '0));

    a_r5_killed_no_wb: assert property (@(posedge clk) disable iff (rst)
        wb_vld |-> !kill_req[wb_idx]);

    a_r5_killed_inactive: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((act_q & $past(kill_req)) == '0));

    a_r6_prio_order: assert property (@(posedge clk) disable iff (rst)
        lch_vld |-> !better);

    a_r7_valid_tracks_elig: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (lch_vld == $past(|elig)));

endmodule

bind thr_sched thr_sched_chk #(.NTHR(NTHR), .PW(PW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .lch_vld   (lch_vld),
    .lch_idx   (lch_idx),
    .wb_vld    (wb_vld),
    .wb_idx    (wb_idx),
    .busy      (busy),
    .elig      (elig),
    .act_q     (act_q),
    .stall_req (stall_req),
    .kill_req  (kill_req),
    .prio      (prio)
);

// File: tb/sim_thr_sched.sv
module sim_thr_sched;
    localparam int D  = 8;
    localparam int C  = 3;
    localparam int SW = 8;
    localparam int PW = 2;
    localparam int IW = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [D-1:0]    ins_req = '0, stall_req = '0, kill_req = '0;
    logic [D*PW-1:0] prio = '0;
    logic [SW-1:0]   ret_data = '0;
    logic            ret_keep = 1'b0;
    logic            lch_vld, wb_vld;
    logic [IW-1:0]   lch_idx, wb_idx;
    logic [SW-1:0]   lch_state;

    always #2.5 clk = ~clk;

    thr_sched #(.NTHR(D), .NSTG(C), .SW(SW), .PW(PW)) u0 (
        .clk(clk), .rst(rst), .ins_req(ins_req), .stall_req(stall_req),
        .kill_req(kill_req), .prio(prio), .ret_data(ret_data),
        .ret_keep(ret_keep), .lch_vld(lch_vld), .lch_idx(lch_idx),
        .lch_state(lch_state), .wb_vld(wb_vld), .wb_idx(wb_idx)
    );

    int nvec = 0, nbad = 0, nlch = 0;
    bit done = 0;

    // reference state
    bit            m_act [D];
    logic [SW-1:0] m_mem [D];
    bit            h_v [C], h_d [C];
    int            h_i [C];
    logic [SW-1:0] h_s [C];
    bit            e_v = 0;
    int            e_i = 0;
    logic [SW-1:0] e_s = '0;
    logic [D-1:0]  b_prev = '0, s_prev = '0;
    logic [31:0]   seed = 32'h1234_5678;

    task automatic chk(string req, int act, int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] nx(logic [31:0] s);
        logic [31:0] r;
        r = s ^ (s << 13);
        r = r ^ (r >> 17);
        r = r ^ (r << 5);
        return r;
    endfunction

    task automatic rnd(output logic [31:0] v);
        seed = nx(seed);
        v = seed;
    endtask

    task automatic step(input logic [D-1:0] ins, input logic [D-1:0] st,
                        input logic [D-1:0] kl, input logic [D*PW-1:0] pr,
                        input bit kp);
        bit            wbv, we;
        logic [SW-1:0] wd;
        logic [D-1:0]  bz;
        int            best;
        @(negedge clk);
        chk("R7", lch_vld, e_v);
        if (lch_vld) nlch++;
        if (e_v && lch_vld) begin
            chk("R6", lch_idx, e_i);
            chk("R2/R8/R9", lch_state, e_s);
            chk("R3", b_prev[lch_idx], 0);
            chk("R4", s_prev[lch_idx], 0);
        end
        ins_req = ins; stall_req = st; kill_req = kl; prio = pr; ret_keep = kp;
        ret_data = h_s[C-1] + 1'b1;
        #1;
        wbv = h_v[C-1] && !h_d[C-1] && !kl[h_i[C-1]];
        chk("R5", wb_vld, wbv);
        if (wbv) chk("R2", wb_idx, h_i[C-1]);
        we = wbv && !kp;
        wd = ret_data;
        bz = '0;
        for (int k = 0; k < C-1; k++) if (h_v[k]) bz[h_i[k]] = 1'b1;
        best = -1;
        for (int i = 0; i < D; i++) begin
            if (m_act[i] && !st[i] && !kl[i] && !bz[i]) begin
                if (best < 0 || pr[i*PW +: PW] > pr[best*PW +: PW]) best = i;
            end
        end
        e_v = (best >= 0);
        if (e_v) begin
            e_i = best;
            e_s = (we && h_i[C-1] == best) ? wd : m_mem[best];
        end
        if (we) m_mem[h_i[C-1]] = wd;
        for (int k = C-1; k > 0; k--) begin
            h_v[k] = h_v[k-1];
            h_i[k] = h_i[k-1];
            h_s[k] = h_s[k-1];
            h_d[k] = h_d[k-1] | kl[h_i[k-1]];
        end
        h_v[0] = e_v; h_i[0] = e_v ? best : 0; h_d[0] = 0; h_s[0] = e_s;
        for (int i = 0; i < D; i++) m_act[i] = (m_act[i] | ins[i]) & !kl[i];
        b_prev = bz;
        s_prev = st;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        logic [31:0] a, b, c;
        logic [D*PW-1:0] pr;
        int n0;
        for (int i = 0; i < D; i++) begin m_act[i] = 0; m_mem[i] = '0; end
        for (int k = 0; k < C; k++) begin h_v[k] = 0; h_d[k] = 0; h_i[k] = 0; h_s[k] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", lch_vld, 0);
        chk("R1", wb_vld, 0);
        rst = 1'b0;
        // R1/R7: idle set after reset, nothing launches
        repeat (8) step('0, '0, '0, '0, 0);
        // R4: fill every thread, equal priorities
        step('1, '0, '0, '0, 0);
        repeat (60) step('0, '0, '0, '0, 0);
        // R6/R4/R8: random priorities, stalls and hold
        for (int n = 0; n < 400; n++) begin
            rnd(a); rnd(b); rnd(c);
            step('0, D'(a & b), '0, (D*PW)'(c), b[20] & a[9]);
        end
        // R5: random inserts and kills
        for (int n = 0; n < 500; n++) begin
            rnd(a); rnd(b); rnd(c);
            step(D'(a & b), D'(c >> 8) & D'(a >> 16), D'(a & b & c >> 3),
                 (D*PW)'(c), b[5]);
        end
        // R3/R9: one thread left, cadence of C with forwarded state
        pr = '0;
        step(D'(4), '0, ~D'(4), pr, 0);
        repeat (6) step('0, '0, '0, pr, 0);
        n0 = nlch;
        repeat (30) step('0, '0, '0, pr, 0);
        chk("R3", nlch - n0, 30 / C);
        // R8: hold keeps the stored state of the single thread
        repeat (30) step('0, '0, '0, pr, 1);
        // R6: priority sweep over a full set
        step('1, '0, '0, pr, 0);
        for (int n = 0; n < 256; n++) begin
            for (int i = 0; i < D; i++) pr[i*PW +: PW] = PW'((n >> (i % 4)) + i);
            step('0, '0, '0, pr, 0);
        end
        step('0, '0, '0, pr, 0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule